// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block produces the bit clock and the left/right frame clock for a two-direction serial audio port. It runs entirely on the master audio clock. When it owns the clocks, a bit divider splits the master clock down to the bit clock. Two frame dividers then count bit clocks, one for the transmit lane and one for the receive lane, to form each lane's frame clock. A share option makes the receive lane reuse the transmit clocks, so one clock pair serves both directions.

When the port is a clock follower, the generated clocks are replaced by clock pins driven from outside. Each lane has its own pin pair, and the block brings them into the master clock domain through a synchronizer. Each lane also gets a single-cycle strobe that marks the start of every frame, which is the start of the left channel. Divider settings are captured only at frame boundaries. This lets software retune a running port without producing a truncated frame.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is held, both bit clocks and both frame clocks are high and both frame strobes are low. After reset is released, the first transmit and receive frame strobes appear in the same cycle.
- R2: In generator mode the bit clock period is `cfg_bit_div` master cycles. It is high for floor(N/2) cycles and low for the rest, and it falls at the start of each period.
- R3: A bit divider or frame length value of 0 or 1 behaves as 2.
- R4: In generator mode the transmit frame lasts `cfg_tx_frame_len` (F) bit clocks. The frame clock is low (left channel) for F minus floor(F/2) bit periods and high (right channel) for the rest. `tx_frame_stb` is high for exactly one master cycle, in the first cycle of the left half, and in that cycle the bit clock and frame clock are both low.
- R5: In generator mode a frame clock changes level only in a cycle where the bit clock has just fallen.
- R6: With sharing off, the receive frame length follows `cfg_rx_frame_len`, independent of the transmit length.
- R7: With `cfg_share` = 1, the receive bit clock, frame clock and strobe equal the transmit ones in every cycle.
- R8: A change to a frame length takes effect at that lane's next frame boundary. A change to the bit divider takes effect at the next transmit frame boundary. The frame in progress finishes with the old settings.
- R9: With `cfg_master` = 0, each lane's outputs follow that lane's clock pins. Output levels appear at the second master clock edge after the pin changes. The lane's frame strobe is high for one cycle, in the cycle the synchronized frame clock first reads low.
- R10: With `cfg_master` = 0 and `cfg_share` = 1, the receive outputs follow the transmit pins, and the receive pins are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_master | input | 1 | 1: generate clocks; 0: follow the clock pins |
| cfg_share | input | 1 | 1: receive lane uses the transmit clocks |
| cfg_bit_div | input | BDIV_W | Master cycles per bit clock period |
| cfg_tx_frame_len | input | FDIV_W | Bit clocks per transmit frame |
| cfg_rx_frame_len | input | FDIV_W | Bit clocks per receive frame |
| pin_tx_bclk | input | 1 | External transmit bit clock |
| pin_tx_fclk | input | 1 | External transmit frame clock |
| pin_rx_bclk | input | 1 | External receive bit clock |
| pin_rx_fclk | input | 1 | External receive frame clock |
| tx_bclk | output | 1 | Transmit bit clock |
| tx_fclk | output | 1 | Transmit frame clock (low = left) |
| tx_frame_stb | output | 1 | Transmit frame-start strobe |
| rx_bclk | output | 1 | Receive bit clock |
| rx_fclk | output | 1 | Receive frame clock (low = left) |
| rx_frame_stb | output | 1 | Receive frame-start strobe |

## Verification
The bench builds the block with `BDIV_W` = 4 and `FDIV_W` = 6. At these widths the largest bit divider (15) and the clamped values 0 and 1 are reached in a few dozen cycles. Short frames of 4 to 8 bit clocks keep every frame under a hundred master cycles, so period, odd-length duty, mid-frame retuning and the independent receive length can all be measured edge by edge. Follower mode is exercised by driving the pins at chosen cycles and counting the synchronizer delay exactly.

// File: rtl/acg_pkg.sv
package acg_pkg;

  // Where a lane's clocks come from
  typedef enum logic {
    SRC_PINS    = 1'b0,
    SRC_DIVIDER = 1'b1
  } clk_src_e;

  // One lane's clock bundle
  typedef struct packed {
    logic bclk;
    logic fclk;
    logic stb;
  } lane_t;

  localparam int MIN_DIVISOR = 2;

endpackage

// File: rtl/acg_bit_div.sv
module acg_bit_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_div,
  input  logic         reload,
  output logic         bclk,
  output logic         wrap
);
  import acg_pkg::*;

  localparam logic [W-1:0] MIN_DIV = W'(MIN_DIVISOR);

  logic [W-1:0] div_q, div_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] low_len;
  logic [W-1:0] cfg_clamped;
  logic         bclk_q, bclk_d;

  assign cfg_clamped = (cfg_div < MIN_DIV) ? MIN_DIV : cfg_div;

  // Next state: count master cycles, reload divisor only on wrap
  always_comb begin
    wrap  = (cnt_q == div_q - W'(1));
    div_d = div_q;
    cnt_d = cnt_q + W'(1);
    if (wrap) begin
      cnt_d = '0;
      if (reload) begin
        div_d = cfg_clamped;
      end
    end
    low_len = div_d - (div_d >> 1);
    bclk_d  = (cnt_d >= low_len);
  end

  // Reset sits on the terminal count so the first edge starts a period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= MIN_DIV;
      cnt_q  <= MIN_DIV - W'(1);
      bclk_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk = bclk_q;

  // R2
  bclk_fall_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk_q) |-> $past(wrap));

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q);

endmodule

// File: rtl/acg_frame_div.sv
module acg_frame_div #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cfg_len,
  output logic         fclk,
  output logic         stb,
  output logic         boundary
);
  import acg_pkg::*;

  localparam logic [W-1:0] MIN_LEN = W'(MIN_DIVISOR);

  logic [W-1:0] len_q, len_d;
  logic [W-1:0] bit_q, bit_d;
  logic [W-1:0] left_len;
  logic [W-1:0] cfg_clamped;
  logic         fclk_q, fclk_d;
  logic         stb_q, stb_d;

  assign cfg_clamped = (cfg_len < MIN_LEN) ? MIN_LEN : cfg_len;

  // Next state: advance once per bit clock fall (tick acts as enable)
  always_comb begin
    boundary = tick && (bit_q == len_q - W'(1));
    bit_d    = bit_q;
    len_d    = len_q;
    stb_d    = 1'b0;
    if (tick) begin
      if (boundary) begin
        bit_d = '0;
        len_d = cfg_clamped;
        stb_d = 1'b1;
      end else begin
        bit_d = bit_q + W'(1);
      end
    end
    left_len = len_d - (len_d >> 1);
    fclk_d   = tick ? (bit_d >= left_len) : fclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= MIN_LEN;
      bit_q  <= MIN_LEN - W'(1);
      fclk_q <= 1'b1;
      stb_q  <= 1'b0;
    end else begin
      len_q  <= len_d;
      bit_q  <= bit_d;
      fclk_q <= fclk_d;
      stb_q  <= stb_d;
    end
  end

  assign fclk = fclk_q;
  assign stb  = stb_q;

  // R5
  fclk_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fclk_q) |-> $past(tick));

  // R4
  stb_starts_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> !fclk_q);

  // R4
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

endmodule

// File: rtl/acg_pin_sync.sv
module acg_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_pin,
  input  logic fclk_pin,
  output logic bclk,
  output logic fclk,
  output logic fclk_fall
);

  localparam int NBITS = 2;

  logic [NBITS-1:0] pins;
  logic [NBITS-1:0] meta_q;
  logic [NBITS-1:0] lvl_q;
  logic             fclk_prev_q;

  assign pins = {fclk_pin, bclk_pin};

  for (genvar i = 0; i < NBITS; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        lvl_q[i]  <= 1'b0;
      end else begin
        meta_q[i] <= pins[i];
        lvl_q[i]  <= meta_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_prev_q <= 1'b0;
    end else begin
      fclk_prev_q <= lvl_q[1];
    end
  end

  assign bclk      = lvl_q[0];
  assign fclk      = lvl_q[1];
  assign fclk_fall = fclk_prev_q & ~lvl_q[1];

  // R9
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fclk_fall |=> !fclk_fall);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int BDIV_W = 8,
  parameter int FDIV_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_share,
  input  logic [BDIV_W-1:0] cfg_bit_div,
  input  logic [FDIV_W-1:0] cfg_tx_frame_len,
  input  logic [FDIV_W-1:0] cfg_rx_frame_len,
  input  logic              pin_tx_bclk,
  input  logic              pin_tx_fclk,
  input  logic              pin_rx_bclk,
  input  logic              pin_rx_fclk,
  output logic              tx_bclk,
  output logic              tx_fclk,
  output logic              tx_frame_stb,
  output logic              rx_bclk,
  output logic              rx_fclk,
  output logic              rx_frame_stb
);
  import acg_pkg::*;

  localparam int NLANE = 2;
  localparam int TX = 0;
  localparam int RX = 1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              bclk_int, bit_wrap;
  logic [FDIV_W-1:0] flen   [NLANE];
  logic [NLANE-1:0]  f_fclk, f_stb, f_bound;
  logic [NLANE-1:0]  p_bclk, p_fclk, p_fall;
  logic [NLANE-1:0]  pin_b, pin_f;

  assign flen[TX] = cfg_tx_frame_len;
  assign flen[RX] = cfg_rx_frame_len;
  assign pin_b    = {pin_rx_bclk, pin_tx_bclk};
  assign pin_f    = {pin_rx_fclk, pin_tx_fclk};

  acg_bit_div #(.W(BDIV_W)) u_bit_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg_div (cfg_bit_div),
    .reload  (f_bound[TX]),
    .bclk    (bclk_int),
    .wrap    (bit_wrap)
  );

  for (genvar d = 0; d < NLANE; d++) begin : g_lane
    acg_frame_div #(.W(FDIV_W)) u_frame_div (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .tick     (bit_wrap),
      .cfg_len  (flen[d]),
      .fclk     (f_fclk[d]),
      .stb      (f_stb[d]),
      .boundary (f_bound[d])
    );

    acg_pin_sync u_pin_sync (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .bclk_pin  (pin_b[d]),
      .fclk_pin  (pin_f[d]),
      .bclk      (p_bclk[d]),
      .fclk      (p_fclk[d]),
      .fclk_fall (p_fall[d])
    );

    // R4
    bound_then_stb_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      f_bound[d] |=> f_stb[d]);
  end

  // Lane selection
  lane_t    tx_gen, rx_gen, tx_pin, rx_pin, tx_lane, rx_lane;
  clk_src_e src;

  always_comb begin
    src    = clk_src_e'(cfg_master);
    tx_gen = '{bclk: bclk_int, fclk: f_fclk[TX], stb: f_stb[TX]};
    rx_gen = cfg_share ? tx_gen
                       : '{bclk: bclk_int, fclk: f_fclk[RX], stb: f_stb[RX]};
    tx_pin = '{bclk: p_bclk[TX], fclk: p_fclk[TX], stb: p_fall[TX]};
    rx_pin = cfg_share ? tx_pin
                       : '{bclk: p_bclk[RX], fclk: p_fclk[RX], stb: p_fall[RX]};
    tx_lane = (src == SRC_DIVIDER) ? tx_gen : tx_pin;
    rx_lane = (src == SRC_DIVIDER) ? rx_gen : rx_pin;
  end

  assign tx_bclk      = tx_lane.bclk;
  assign tx_fclk      = tx_lane.fclk;
  assign tx_frame_stb = tx_lane.stb;
  assign rx_bclk      = rx_lane.bclk;
  assign rx_fclk      = rx_lane.fclk;
  assign rx_frame_stb = rx_lane.stb;

  // R4
  master_stb_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_master && tx_frame_stb) |-> (!tx_bclk && !tx_fclk));

endmodule

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;

  localparam int BW = 4;
  localparam int FW = 6;

  logic          clk, rst_n;
  logic          cfg_master, cfg_share;
  logic [BW-1:0] cfg_bit_div;
  logic [FW-1:0] cfg_tx_frame_len, cfg_rx_frame_len;
  logic          pin_tx_bclk, pin_tx_fclk, pin_rx_bclk, pin_rx_fclk;
  logic          tx_bclk, tx_fclk, tx_frame_stb;
  logic          rx_bclk, rx_fclk, rx_frame_stb;

  int  n_checks = 0;
  int  n_bad    = 0;
  bit  done     = 0;

  audio_clkgen #(.BDIV_W(BW), .FDIV_W(FW)) u_audio_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_share(cfg_share),
    .cfg_bit_div(cfg_bit_div), .cfg_tx_frame_len(cfg_tx_frame_len),
    .cfg_rx_frame_len(cfg_rx_frame_len),
    .pin_tx_bclk(pin_tx_bclk), .pin_tx_fclk(pin_tx_fclk),
    .pin_rx_bclk(pin_rx_bclk), .pin_rx_fclk(pin_rx_fclk),
    .tx_bclk(tx_bclk), .tx_fclk(tx_fclk), .tx_frame_stb(tx_frame_stb),
    .rx_bclk(rx_bclk), .rx_fclk(rx_fclk), .rx_frame_stb(rx_frame_stb)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb(input bit rx);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(rx ? rx_frame_stb : tx_frame_stb) && guard < 5000);
  endtask

  // Called on a strobe sample; counts until the next strobe
  task automatic measure_frame(input bit rx, output int period, output int left, output int stbs);
    int guard = 0;
    period = 0; left = 0; stbs = 0;
    do begin
      if (!(rx ? rx_fclk : tx_fclk)) left++;
      if (rx ? rx_frame_stb : tx_frame_stb) stbs++;
      period++;
      @(negedge clk);
      guard++;
    end while (!(rx ? rx_frame_stb : tx_frame_stb) && guard < 5000);
  endtask

  task automatic measure_bclk(output int lo, output int hi);
    int guard = 0;
    wait_stb(0);
    lo = 0; hi = 0;
    while (tx_bclk == 1'b0 && guard < 100) begin lo++; guard++; @(negedge clk); end
    while (tx_bclk == 1'b1 && guard < 200) begin hi++; guard++; @(negedge clk); end
  endtask

  task automatic set_master(input int bdiv, input int ftx, input int frx, input bit share);
    @(negedge clk);
    cfg_master       = 1'b1;
    cfg_share        = share;
    cfg_bit_div      = BW'(bdiv);
    cfg_tx_frame_len = FW'(ftx);
    cfg_rx_frame_len = FW'(frx);
    wait_stb(0);
    wait_stb(0);
  endtask

  task automatic t_reset();
    int tx_seen, rx_seen;
    rst_n = 1'b0;
    cfg_master = 1'b1; cfg_share = 1'b0;
    cfg_bit_div = 4'd4; cfg_tx_frame_len = 6'd8; cfg_rx_frame_len = 6'd6;
    pin_tx_bclk = 0; pin_tx_fclk = 0; pin_rx_bclk = 0; pin_rx_fclk = 0;
    repeat (4) @(negedge clk);
    // R1 reset levels
    check(tx_bclk && tx_fclk && rx_bclk && rx_fclk, "R1 reset clocks high",
          {tx_bclk, tx_fclk, rx_bclk, rx_fclk}, 15);
    check(!tx_frame_stb && !rx_frame_stb, "R1 reset strobes low",
          {tx_frame_stb, rx_frame_stb}, 0);
    rst_n = 1'b1;
    wait_stb(0);
    tx_seen = tx_frame_stb; rx_seen = rx_frame_stb;
    // R1 first frames start together
    check(tx_seen == 1 && rx_seen == 1, "R1 first strobes aligned", rx_seen, 1);
  endtask

  task automatic t_bclk();
    int lo, hi;
    set_master(4, 8, 6, 0);
    measure_bclk(lo, hi);
    check(lo == 2 && hi == 2, "R2 even divider lo", lo, 2);
    check(hi == 2, "R2 even divider hi", hi, 2);
    set_master(5, 8, 6, 0);
    measure_bclk(lo, hi);
    check(lo == 3, "R2 odd divider lo", lo, 3);
    check(hi == 2, "R2 odd divider hi", hi, 2);
    set_master(15, 4, 4, 0);
    measure_bclk(lo, hi);
    check(lo == 8 && hi == 7, "R2 max divider lo+hi", lo * 100 + hi, 807);
  endtask

  task automatic t_clamp();
    int lo, hi, p, l, s;
    set_master(0, 8, 6, 0);
    measure_bclk(lo, hi);
    // R3 divider 0 acts as 2
    check(lo == 1 && hi == 1, "R3 bit divider 0", lo * 100 + hi, 101);
    set_master(2, 1, 6, 0);
    wait_stb(0);
    measure_frame(0, p, l, s);
    // R3 frame length 1 acts as 2: 2 bits * 2 cycles
    check(p == 4, "R3 frame length 1", p, 4);
  endtask

  task automatic t_tx_frame();
    int p, l, s;
    set_master(4, 8, 6, 0);
    wait_stb(0);
    measure_frame(0, p, l, s);
    check(p == 32, "R4 tx period even", p, 32);
    check(l == 16, "R4 tx left half even", l, 16);
    check(s == 1, "R4 strobe width", s, 1);
    set_master(2, 5, 6, 0);
    wait_stb(0);
    measure_frame(0, p, l, s);
    check(p == 10, "R4 tx period odd", p, 10);
    check(l == 6, "R4 tx left half odd", l, 6);
  endtask

  task automatic t_fclk_edge();
    logic pb, pf;
    int   bad = 0;
    set_master(3, 6, 4, 0);
    pb = tx_bclk; pf = tx_fclk;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tx_fclk != pf && !(pb == 1'b1 && tx_bclk == 1'b0)) bad++;
      pb = tx_bclk; pf = tx_fclk;
    end
    // R5
    check(bad == 0, "R5 fclk moves with bclk fall", bad, 0);
  endtask

  task automatic t_rx_indep();
    int p, l, s;
    set_master(4, 8, 6, 0);
    wait_stb(1);
    measure_frame(1, p, l, s);
    check(p == 24, "R6 rx period", p, 24);
    check(l == 12, "R6 rx left half", l, 12);
  endtask

  task automatic t_share();
    int bad = 0;
    set_master(4, 8, 6, 1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rx_bclk != tx_bclk || rx_fclk != tx_fclk || rx_frame_stb != tx_frame_stb) bad++;
    end
    // R7
    check(bad == 0, "R7 rx mirrors tx", bad, 0);
  endtask

  task automatic t_retune();
    int p = 0, l, s, guard = 0;
    set_master(4, 8, 6, 0);
    wait_stb(0);
    do begin
      p++;
      if (p == 5) begin
        cfg_bit_div = 4'd2;
        cfg_tx_frame_len = 6'd4;
      end
      @(negedge clk);
      guard++;
    end while (!tx_frame_stb && guard < 5000);
    // R8 frame in progress keeps old settings
    check(p == 32, "R8 current frame unchanged", p, 32);
    measure_frame(0, p, l, s);
    check(p == 8, "R8 next frame retuned", p, 8);
  endtask

  task automatic t_slave();
    @(negedge clk);
    cfg_master = 1'b0; cfg_share = 1'b0;
    pin_tx_fclk = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_fclk == 1'b1, "R9 fclk follows pin", tx_fclk, 1);
    pin_tx_fclk = 1'b0;
    pin_tx_bclk = 1'b1;
    @(negedge clk);
    check(tx_fclk == 1'b1 && !tx_frame_stb && !tx_bclk, "R9 one edge: unchanged",
          {tx_fclk, tx_frame_stb, tx_bclk}, 4);
    @(negedge clk);
    check(!tx_fclk && tx_frame_stb && tx_bclk, "R9 two edges: new level and strobe",
          {tx_fclk, tx_frame_stb, tx_bclk}, 3);
    @(negedge clk);
    check(!tx_frame_stb, "R9 strobe one cycle", tx_frame_stb, 0);
    pin_rx_bclk = 1'b1; pin_rx_fclk = 1'b1;
    repeat (2) @(negedge clk);
    check(rx_bclk && rx_fclk && !tx_fclk, "R9 rx lane follows own pins",
          {rx_bclk, rx_fclk, tx_fclk}, 6);
  endtask

  task automatic t_slave_share();
    @(negedge clk);
    cfg_master = 1'b0; cfg_share = 1'b1;
    pin_tx_bclk = 1'b0; pin_tx_fclk = 1'b1;
    pin_rx_bclk = 1'b1; pin_rx_fclk = 1'b0;
    repeat (3) @(negedge clk);
    check(!rx_bclk && rx_fclk, "R10 rx from tx pins", {rx_bclk, rx_fclk}, 1);
    pin_tx_fclk = 1'b0;
    pin_rx_fclk = 1'b1;
    repeat (2) @(negedge clk);
    check(rx_frame_stb && !rx_fclk, "R10 rx strobe from tx pin", {rx_frame_stb, rx_fclk}, 2);
  endtask

  initial begin
    t_reset();
    t_bclk();
    t_clamp();
    t_tx_frame();
    t_fclk_edge();
    t_rx_indep();
    t_share();
    t_retune();
    t_slave();
    t_slave_share();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #1500us;
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule